// File: doc/BRIEF.md
# SDRAM Command Decoder and Power-State Tracker

This block sits on the device side of a four-bank double-data-rate SDRAM control bus and follows what the controller asks of the memory. On every rising clock edge it samples the clock-enable line, the four active-low command strobes (chip select, row strobe, column strobe, write enable), a two-bit bank select and a 13-bit address. It turns them into bank activations, single-bank and all-bank closes, refreshes, mode register writes and the entries into and exits from the two low-power states.

The same strobe pattern can mean different commands. The block keeps the clock-enable level of the previous cycle and compares it with the current one. A refresh pattern with clock-enable held high is an auto-refresh. The same pattern with clock-enable falling enters self-refresh. A no-operation or deselect with clock-enable falling enters power-down.

Per bank, the block reports whether the bank is open and which row it holds. Globally, it reports whether the device is in normal operation, self-refresh or power-down, along with the two mode register values. Illegal sequences raise a sticky sequence-error flag. A clock-enable level held for only one cycle raises a separate sticky flag. Every reported value is registered and changes one clock after the sampling edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With clock-enable high on the previous and current cycle in normal state, strobes {cs_n,ras_n,cas_n,we_n}=0011 open the bank selected by `ba` and store `addr` as its row, visible on the next cycle.
- R2: Bank index equals the unsigned value of `ba` (ba[0] low bit). Bank k's row occupies `open_rows[13k+12:13k]` and its open flag is `bank_open[k]`.
- R3: Strobes 0010 with clock-enable high on both cycles close only the selected bank when addr[10]=0, and close all banks when addr[10]=1.
- R4: Strobes 0001 with clock-enable high on both cycles are an auto-refresh. With all banks closed nothing changes. With any bank open `seq_err` is set and no state changes.
- R5: Strobes 0001 with clock-enable going 1 to 0 in normal state and all banks closed move `pwr_state` to 01 (self-refresh). With a bank open, `seq_err` is set and the state stays 00.
- R6: A deselect (cs_n=1) or no-operation (0111) with clock-enable going 1 to 0 in normal state and all banks closed moves `pwr_state` to 10 (power-down). With a bank open, `seq_err` is set and the state stays 00.
- R7: In state 01 or 10, a deselect or no-operation with clock-enable going 0 to 1 returns `pwr_state` to 00.
- R8: In state 01 or 10, any cycle other than a deselect or no-operation with clock-enable low on both cycles, and other than the exit of R7, sets `seq_err` and leaves every state unchanged.
- R9: Strobes 0000 with clock-enable high on both cycles write `addr` into `mode_reg` when ba=00 and into `ext_mode_reg` when ba=01. With ba[1]=1 neither register changes.
- R10: An activate to a bank that is already open sets `seq_err` and leaves that bank's row unchanged. `seq_err` stays set until reset.
- R11: When clock-enable changes level and then changes back after a single cycle, `cke_viol` is set and stays set until reset.
- R12: After reset all banks are closed with rows 0, `pwr_state` is 00, both mode registers are 0 and both error flags are 0. The previous clock-enable level is taken as high.
- R13: In normal state, clock-enable falling with a strobe pattern other than those of R5 and R6 sets `seq_err`. So does any cycle with the previous clock-enable low other than a rise with deselect or no-operation. No state changes in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address or mode register value; bit 10 selects all-bank close |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Stored row per bank, 13 bits each |
| pwr_state | output | 2 | 00 normal, 01 self-refresh, 10 power-down |
| mode_reg | output | 13 | Mode register value |
| ext_mode_reg | output | 13 | Extended mode register value |
| seq_err | output | 1 | Sticky illegal-sequence flag |
| cke_viol | output | 1 | Sticky short clock-enable pulse flag |

## Verification
The bench builds the block with its defaults: four banks, 13-bit rows and address bit 10 as the all-bank select. With these values every bank encoding and every clock-enable transition pair are reached within a few thousand cycles. Directed sequences come first and cover each corner case: a re-activate, a refresh with an open bank, each low-power entry and exit, the ignored mode-register banks and a one-cycle clock-enable pulse. Random traffic with periodic resets follows, so the sticky flags are cleared and low-power entries keep recurring.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'b00,
    PWR_SELF   = 2'b01,
    PWR_DOWN   = 2'b10
  } pwr_t;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_OTHER
  } cmd_t;

  typedef struct packed {
    logic act;
    logic act_clash;
    logic pre_one;
    logic pre_all;
    logic mrs;
    logic self_in;
    logic pd_in;
    logic lp_out;
    logic err;
  } evt_t;

  // Deselect and no-operation both map to CMD_NOP.
  function automatic cmd_t classify(input logic cs_n, input logic ras_n,
                                    input logic cas_n, input logic we_n);
    cmd_t c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cke,
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic addr_ap,
  input  pwr_t pwr,
  input  logic any_open,
  input  logic sel_open,
  output evt_t evt
);

  cmd_t cmd;
  logic normal, hold_hi, falling, rising, hold_lo, is_nop;
  logic ref_clash, fall_bad, low_bad, lp_bad;

  always_comb begin
    cmd     = classify(cs_n, ras_n, cas_n, we_n);
    is_nop  = (cmd == CMD_NOP);
    normal  = (pwr == PWR_NORMAL);
    hold_hi = cke_q & cke;
    falling = cke_q & ~cke;
    rising  = ~cke_q & cke;
    hold_lo = ~cke_q & ~cke;

    evt.act       = normal & hold_hi & (cmd == CMD_ACT) & ~sel_open;
    evt.act_clash = normal & hold_hi & (cmd == CMD_ACT) & sel_open;
    evt.pre_one   = normal & hold_hi & (cmd == CMD_PRE) & ~addr_ap;
    evt.pre_all   = normal & hold_hi & (cmd == CMD_PRE) & addr_ap;
    evt.mrs       = normal & hold_hi & (cmd == CMD_MRS);
    ref_clash     = normal & hold_hi & (cmd == CMD_REF) & any_open;

    evt.self_in   = normal & falling & (cmd == CMD_REF) & ~any_open;
    evt.pd_in     = normal & falling & is_nop & ~any_open;
    fall_bad      = normal & falling & ~evt.self_in & ~evt.pd_in;
    low_bad       = normal & ~cke_q & ~(cke & is_nop);

    evt.lp_out    = ~normal & rising & is_nop;
    lp_bad        = ~normal & ~(hold_lo & is_nop) & ~evt.lp_out;

    evt.err = evt.act_clash | ref_clash | fall_bad | low_bad | lp_bad;
  end

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act,
  input  logic                       pre_one,
  input  logic                       pre_all,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           row_in,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       sel_open,
  output logic                       any_open
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    logic [ROW_W-1:0] row_q;
    assign hit = (ba == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        row_q        <= '0;
      end else if (act && hit) begin
        bank_open[b] <= 1'b1;
        row_q        <= row_in;
      end else if (pre_all || (pre_one && hit)) begin
        bank_open[b] <= 1'b0;
      end
    end

    assign open_rows[b*ROW_W +: ROW_W] = row_q;
  end

  assign sel_open = bank_open[ba];
  assign any_open = |bank_open;

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
  parameter int VAL_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs,
  input  logic [BA_W-1:0]  ba,
  input  logic [VAL_W-1:0] value,
  output logic [VAL_W-1:0] mode_reg,
  output logic [VAL_W-1:0] ext_mode_reg
);

  logic sel_base, sel_ext;
  assign sel_base = mrs && (ba == BA_W'(0));
  assign sel_ext  = mrs && (ba == BA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_reg     <= '0;
      ext_mode_reg <= '0;
    end else begin
      if (sel_base) mode_reg     <= value;
      if (sel_ext)  ext_mode_reg <= value;
    end
  end

endmodule

// File: rtl/sdram_power_track.sv
module sdram_power_track
  import sdram_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic self_in,
  input  logic pd_in,
  input  logic lp_out,
  input  logic err_evt,
  output pwr_t pwr,
  output logic cke_q,
  output logic seq_err,
  output logic cke_viol
);

  logic cke_q2;
  logic short_pulse;

  assign short_pulse = (cke != cke_q) && (cke_q != cke_q2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr      <= PWR_NORMAL;
      cke_q    <= 1'b1;
      cke_q2   <= 1'b1;
      seq_err  <= 1'b0;
      cke_viol <= 1'b0;
    end else begin
      cke_q  <= cke;
      cke_q2 <= cke_q;
      if (self_in)     pwr <= PWR_SELF;
      else if (pd_in)  pwr <= PWR_DOWN;
      else if (lp_out) pwr <= PWR_NORMAL;
      if (err_evt)     seq_err  <= 1'b1;
      if (short_pulse) cke_viol <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [1:0]                 pwr_state,
  output logic [ROW_W-1:0]           mode_reg,
  output logic [ROW_W-1:0]           ext_mode_reg,
  output logic                       seq_err,
  output logic                       cke_viol
);

  evt_t evt;
  pwr_t pwr;
  logic cke_q, sel_open, any_open;

  // Named event wires, observed by the bound checker.
  logic act_fire, act_clash, pre_fire, pall_fire, mrs_fire;
  logic self_fire, pd_fire, exit_fire, err_fire;
  assign act_fire  = evt.act;
  assign act_clash = evt.act_clash;
  assign pre_fire  = evt.pre_one;
  assign pall_fire = evt.pre_all;
  assign mrs_fire  = evt.mrs;
  assign self_fire = evt.self_in;
  assign pd_fire   = evt.pd_in;
  assign exit_fire = evt.lp_out;
  assign err_fire  = evt.err;

  sdram_cmd_decode u_dec (
    .cke      (cke),
    .cke_q    (cke_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr_ap  (addr[AP_BIT]),
    .pwr      (pwr),
    .any_open (any_open),
    .sel_open (sel_open),
    .evt      (evt)
  );

  sdram_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act_fire),
    .pre_one   (pre_fire),
    .pre_all   (pall_fire),
    .ba        (ba),
    .row_in    (addr),
    .bank_open (bank_open),
    .open_rows (open_rows),
    .sel_open  (sel_open),
    .any_open  (any_open)
  );

  sdram_mode_regs #(.VAL_W(ROW_W), .BA_W(BA_W)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mrs          (mrs_fire),
    .ba           (ba),
    .value        (addr),
    .mode_reg     (mode_reg),
    .ext_mode_reg (ext_mode_reg)
  );

  sdram_power_track u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .self_in  (self_fire),
    .pd_in    (pd_fire),
    .lp_out   (exit_fire),
    .err_evt  (err_fire),
    .pwr      (pwr),
    .cke_q    (cke_q),
    .seq_err  (seq_err),
    .cke_viol (cke_viol)
  );

  assign pwr_state = pwr;

endmodule

// File: rtl/sdram_trk_checker.sv
module sdram_trk_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [BA_W-1:0]      ba,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [1:0]           pwr_state,
  input logic [ROW_W-1:0]     mode_reg,
  input logic [ROW_W-1:0]     ext_mode_reg,
  input logic                 seq_err,
  input logic                 cke_viol,
  input logic                 act_fire,
  input logic                 act_clash,
  input logic                 pall_fire,
  input logic                 mrs_fire,
  input logic                 exit_fire,
  input logic                 err_fire
);

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> bank_open[$past(ba)]);

  assert_close_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pall_fire |=> (bank_open == '0));

  assert_lowpwr_banks_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b00) |-> (bank_open == '0));

  assert_state_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_state) <= 1);

  assert_exit_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_fire |=> (pwr_state == 2'b00));

  assert_err_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> seq_err);

  assert_mode_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_fire && ba[BA_W-1]) |=> ($stable(mode_reg) && $stable(ext_mode_reg)));

  assert_reopen_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_clash |=> seq_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  assert_viol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cke_viol |=> cke_viol);

endmodule

bind sdram_cmd_tracker sdram_trk_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ba           (ba),
  .bank_open    (bank_open),
  .pwr_state    (pwr_state),
  .mode_reg     (mode_reg),
  .ext_mode_reg (ext_mode_reg),
  .seq_err      (seq_err),
  .cke_viol     (cke_viol),
  .act_fire     (act_fire),
  .act_clash    (act_clash),
  .pall_fire    (pall_fire),
  .mrs_fire     (mrs_fire),
  .exit_fire    (exit_fire),
  .err_fire     (err_fire)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  localparam int NB = 4;
  localparam int RW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic [3:0] strobes = 4'b1111;
  logic [1:0] ba = 2'b00;
  logic [RW-1:0] addr = '0;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] open_rows;
  logic [1:0] pwr_state;
  logic [RW-1:0] mode_reg, ext_mode_reg;
  logic seq_err, cke_viol;

  always #2 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .cs_n(strobes[3]), .ras_n(strobes[2]), .cas_n(strobes[1]), .we_n(strobes[0]),
    .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_rows(open_rows), .pwr_state(pwr_state),
    .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
    .seq_err(seq_err), .cke_viol(cke_viol)
  );

  // Strobe codes {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1111, C_ACT = 4'b0011,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_BST = 4'b0110;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  bit m_open[NB];
  int m_row[NB];
  int m_pwr;
  int m_mr, m_emr;
  bit m_err, m_viol, m_ck1, m_ck2;

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
    m_pwr = 0; m_mr = 0; m_emr = 0; m_err = 0; m_viol = 0; m_ck1 = 1; m_ck2 = 1;
  endtask

  task automatic model_step();
    bit nop, anyo, bad;
    nop  = strobes[3] || (strobes[2:0] == 3'b111);
    anyo = 0;
    bad  = 0;
    for (int b = 0; b < NB; b++) if (m_open[b]) anyo = 1;
    if (m_pwr == 0) begin
      if (m_ck1 && cke) begin
        if (strobes == C_ACT) begin
          if (m_open[ba]) bad = 1;
          else begin m_open[ba] = 1; m_row[ba] = int'(addr); end
        end else if (strobes == C_PRE) begin
          if (addr[10]) for (int b = 0; b < NB; b++) m_open[b] = 0;
          else m_open[ba] = 0;
        end else if (strobes == C_REF) begin
          if (anyo) bad = 1;
        end else if (strobes == C_MRS) begin
          if (ba == 2'd0) m_mr = int'(addr);
          else if (ba == 2'd1) m_emr = int'(addr);
        end
      end else if (m_ck1 && !cke) begin
        if (!anyo && strobes == C_REF) m_pwr = 1;
        else if (!anyo && nop) m_pwr = 2;
        else bad = 1;
      end else begin
        if (!(cke && nop)) bad = 1;
      end
    end else begin
      if (!m_ck1 && cke && nop) m_pwr = 0;
      else if (!(!m_ck1 && !cke && nop)) bad = 1;
    end
    if (bad) m_err = 1;
    if ((cke != m_ck1) && (m_ck1 != m_ck2)) m_viol = 1;
    m_ck2 = m_ck1;
    m_ck1 = cke;
  endtask

  task automatic chk(input string tag, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, req, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int eo;
    eo = 0;
    for (int b = 0; b < NB; b++) if (m_open[b]) eo |= (1 << b);
    chk(tag, "R1 bank_open", int'(bank_open), eo);
    for (int b = 0; b < NB; b++)
      chk(tag, "R2 row", int'(open_rows[b*RW +: RW]), m_row[b]);
    chk(tag, "R5 pwr_state", int'(pwr_state), m_pwr);
    chk(tag, "R9 mode_reg", int'(mode_reg), m_mr);
    chk(tag, "R9 ext_mode_reg", int'(ext_mode_reg), m_emr);
    chk(tag, "R10 seq_err", int'(seq_err), int'(m_err));
    chk(tag, "R11 cke_viol", int'(cke_viol), int'(m_viol));
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(input string tag, input logic k, input logic [3:0] s,
                      input logic [1:0] b, input logic [RW-1:0] a);
    cke = k; strobes = s; ba = b; addr = a;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cke = 1'b1; strobes = C_DES;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    compare("R12 reset");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic k;
    logic [3:0] cs [9];
    cs = '{C_NOP, C_DES, C_ACT, C_PRE, C_REF, C_MRS, C_RD, C_WR, C_BST};
    model_reset();
    @(negedge clk);
    do_reset();

    // Activate, re-activate conflict
    step("R1 act b2", 1, C_ACT, 2'd2, 13'h1ABC);
    step("R2 act b0", 1, C_ACT, 2'd0, 13'h0123);
    step("R10 reopen", 1, C_ACT, 2'd2, 13'h0FFF);
    step("R10 sticky", 1, C_NOP, 2'd0, 13'h0);
    do_reset();

    // Mode registers
    step("R9 mrs", 1, C_MRS, 2'd0, 13'h0A5A);
    step("R9 emrs", 1, C_MRS, 2'd1, 13'h1111);
    step("R9 ignored b2", 1, C_MRS, 2'd2, 13'h1FFF);
    step("R9 ignored b3", 1, C_MRS, 2'd3, 13'h0777);

    // Single and all-bank close
    step("R1 act b1", 1, C_ACT, 2'd1, 13'h0042);
    step("R1 act b3", 1, C_ACT, 2'd3, 13'h1001);
    step("R3 pre b1", 1, C_PRE, 2'd1, 13'h0000);
    step("R3 pall", 1, C_PRE, 2'd0, 13'h0400);
    step("R4 ref idle", 1, C_REF, 2'd0, 13'h0);

    // Self-refresh entry, hold, exit
    step("R5 self in", 0, C_REF, 2'd0, 13'h0);
    step("R8 hold nop", 0, C_NOP, 2'd0, 13'h0);
    step("R8 hold des", 0, C_DES, 2'd0, 13'h0);
    step("R7 exit", 1, C_NOP, 2'd0, 13'h0);
    step("R7 after", 1, C_NOP, 2'd0, 13'h0);

    // Power-down entry, exit
    step("R6 pd in", 0, C_DES, 2'd0, 13'h0);
    step("R6 pd hold", 0, C_NOP, 2'd0, 13'h0);
    step("R7 pd exit", 1, C_DES, 2'd0, 13'h0);
    step("R7 settle", 1, C_NOP, 2'd0, 13'h0);

    // Illegal command during power-down
    step("R6 pd in2", 0, C_NOP, 2'd0, 13'h0);
    step("R6 pd hold2", 0, C_NOP, 2'd0, 13'h0);
    step("R8 act in pd", 0, C_ACT, 2'd1, 13'h0055);
    do_reset();

    // Refresh and entries with an open bank
    step("R4 act", 1, C_ACT, 2'd0, 13'h0010);
    step("R4 ref busy", 1, C_REF, 2'd0, 13'h0);
    do_reset();
    step("R5 act", 1, C_ACT, 2'd3, 13'h0020);
    step("R5 self busy", 0, C_REF, 2'd0, 13'h0);
    do_reset();
    step("R6 act", 1, C_ACT, 2'd1, 13'h0030);
    step("R6 pd busy", 0, C_NOP, 2'd0, 13'h0);
    do_reset();

    // Wrong command on falling clock-enable, low without entry
    step("R13 fall rd", 0, C_RD, 2'd0, 13'h0);
    step("R13 low", 0, C_NOP, 2'd0, 13'h0);
    do_reset();

    // One-cycle clock-enable pulse
    step("R11 pd in", 0, C_NOP, 2'd0, 13'h0);
    step("R11 short", 1, C_NOP, 2'd0, 13'h0);
    step("R11 sticky", 1, C_NOP, 2'd0, 13'h0);
    do_reset();

    // Random traffic with periodic resets
    k = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      if (n % 400 == 399) do_reset();
      if ($urandom_range(0, 5) == 0) k = ~k;
      step("RND", k, cs[$urandom_range(0, 8)], 2'($urandom_range(0, 3)),
           13'($urandom_range(0, 8191)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule